// File: doc/BRIEF.md
# Bytecode Instruction Fetch Buffer

This block sits in front of the decoder of a byte-coded stack machine. Memory holds 16-bit words, and each word packs two 8-bit opcodes. The block keeps a word program counter and a single holding byte for the second opcode of the current word. It hands the decoder one opcode per request. A holding byte equal to zero means that nothing is buffered: opcode zero is a no-operation, so skipping it changes nothing, and the buffer needs no separate valid flag.

The decoder sends four kinds of request: next opcode, next opcode without the interrupt check, operand byte, and jump. A jump names a target word and one byte of it. Each word fetch made for an opcode can be checked against a pending interrupt. The interrupt is taken only when the wakeup-disable count is zero. When that happens, no opcode is delivered, the PC is backed up one word and a flag records which byte execution should resume at. Memory is a simple synchronous read port with one cycle of latency.

The reset value loaded into the PC is the word just before the first word to execute. The first request for an opcode moves the PC up one word and fetches that word.

Top module: `bytecode_fetch`

## Requirements
- R1: While `rst` is high at a clock edge, `pc` takes `start_pc`, the holding byte is emptied, and `op_valid`, `opd_valid` and `irq_stop` go low.
- R2: With the holding byte empty, an accepted `next_req` increments `pc` and reads memory at the new `pc`. Two cycles after the request, `op_byte` carries bits [15:8] of that word with `op_valid` high, and bits [7:0] become the holding byte.
- R3: With a non-zero holding byte, an accepted `next_req` or `next_deaf_req` delivers that byte on `op_byte` one cycle later, empties the holding byte, leaves `pc` unchanged and makes no memory read.
- R4: A fetched word whose bits [7:0] are zero leaves the holding byte empty, so the following opcode request fetches the next word.
- R5: An accepted `jump_req` with `jump_odd`=0 sets `pc` to `jump_pc` and reads that word. Two cycles later it delivers bits [15:8] and buffers bits [7:0]. `jump_req` takes priority over `opd_req`, which takes priority over `next_req`/`next_deaf_req`.
- R6: An accepted `jump_req` with `jump_odd`=1 reads `jump_pc` and discards bits [15:8]. Two cycles later it delivers bits [7:0] on `op_byte` and leaves the holding byte empty.
- R7: With a non-zero holding byte, an accepted `opd_req` returns that byte on `opd_byte` with `opd_valid` one cycle later and empties the holding byte. `pc` does not change.
- R8: With the holding byte empty, an accepted `opd_req` increments `pc` and reads that word. Two cycles later it returns bits [15:8] as the operand and buffers bits [7:0]. This fetch is never checked for interrupts.
- R9: On a checked opcode fetch (`next_req` or `jump_req` with `jump_deaf`=0) while `irq_pending`=1 and `wdc`=0, the block delivers no opcode. It pulses `irq_stop`, sets `pc` to the fetched word minus one and empties the holding byte. It sets `resume_odd` to 0 for an even-byte entry and to 1 for an odd-byte jump.
- R10: A non-zero `wdc` blocks the interrupt: the fetch delivers its opcode as in R2, R5 or R6.
- R11: `next_deaf_req`, and `jump_req` with `jump_deaf`=1, ignore `irq_pending` entirely.
- R12: Each of `op_valid`, `opd_valid` and `irq_stop` lasts one cycle per event, and at most one of them is high at a time. Requests made while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_pc | input | ADDR_W | PC value loaded at reset |
| next_req | input | 1 | Request next opcode, interrupt-checked |
| next_deaf_req | input | 1 | Request next opcode without interrupt check |
| opd_req | input | 1 | Request an operand byte |
| jump_req | input | 1 | Jump request |
| jump_pc | input | ADDR_W | Jump target word |
| jump_odd | input | 1 | Jump enters at the low byte |
| jump_deaf | input | 1 | Jump fetch skips interrupt check |
| irq_pending | input | 1 | Interrupt pending |
| wdc | input | WDC_W | Wakeup-disable count; interrupts allowed only at zero |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory word address |
| mem_data | input | 2*BYTE_W | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | A fetch is in flight; requests ignored |
| op_valid | output | 1 | Opcode strobe |
| op_byte | output | BYTE_W | Opcode |
| opd_valid | output | 1 | Operand strobe |
| opd_byte | output | BYTE_W | Operand byte |
| irq_stop | output | 1 | Interrupt taken |
| resume_odd | output | 1 | Resume byte of the last taken interrupt |
| pc | output | ADDR_W | Word program counter |

## Verification
The assertions assume that `mem_data` answers a read exactly one cycle after `mem_rd`. They also assume that `irq_pending` and `wdc` stay steady from the request until its word returns, because the interrupt decision samples them in the return cycle. The bench's memory model is a registered read of a word computed from its address. The bench holds the interrupt inputs constant across each whole request and only changes them while the block is idle. When it pokes a request during a busy cycle, it does so on purpose, to show that the request is dropped.

// File: rtl/bytecode_fetch.sv
module bytecode_fetch #(
  parameter int ADDR_W = 16,
  parameter int BYTE_W = 8,
  parameter int WDC_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] start_pc,
  input  logic              next_req,
  input  logic              next_deaf_req,
  input  logic              opd_req,
  input  logic              jump_req,
  input  logic [ADDR_W-1:0] jump_pc,
  input  logic              jump_odd,
  input  logic              jump_deaf,
  input  logic              irq_pending,
  input  logic [WDC_W-1:0]  wdc,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [2*BYTE_W-1:0] mem_data,
  output logic              busy,
  output logic              op_valid,
  output logic [BYTE_W-1:0] op_byte,
  output logic              opd_valid,
  output logic [BYTE_W-1:0] opd_byte,
  output logic              irq_stop,
  output logic              resume_odd,
  output logic [ADDR_W-1:0] pc
);

  typedef enum logic [1:0] {IDLE, W_EVEN, W_ODD, W_OPND} st_t;

  st_t               st;
  logic [BYTE_W-1:0] hold;
  logic              chk;
  logic              any_next, hold_empty, take_irq;
  logic [BYTE_W-1:0] hi_b, lo_b;

  assign busy       = (st != IDLE);
  assign any_next   = next_req | next_deaf_req;
  assign hold_empty = (hold == '0);
  assign hi_b       = mem_data[2*BYTE_W-1:BYTE_W];
  assign lo_b       = mem_data[BYTE_W-1:0];
  assign take_irq   = chk && irq_pending && (wdc == '0);

  always_comb begin
    mem_rd   = 1'b0;
    mem_addr = pc + 1'b1;
    if (!rst && st == IDLE) begin
      if (jump_req) begin
        mem_rd   = 1'b1;
        mem_addr = jump_pc;
      end else if ((opd_req || any_next) && hold_empty) begin
        mem_rd = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= IDLE;
      pc         <= start_pc;
      hold       <= '0;
      chk        <= 1'b0;
      op_valid   <= 1'b0;
      opd_valid  <= 1'b0;
      irq_stop   <= 1'b0;
      resume_odd <= 1'b0;
      op_byte    <= '0;
      opd_byte   <= '0;
    end else begin
      op_valid  <= 1'b0;
      opd_valid <= 1'b0;
      irq_stop  <= 1'b0;
      case (st)
        IDLE: begin
          if (jump_req) begin
            pc   <= jump_pc;
            hold <= '0;
            chk  <= !jump_deaf;
            st   <= jump_odd ? W_ODD : W_EVEN;
          end else if (opd_req) begin
            if (!hold_empty) begin
              opd_valid <= 1'b1;
              opd_byte  <= hold;
              hold      <= '0;
            end else begin
              pc  <= pc + 1'b1;
              chk <= 1'b0;
              st  <= W_OPND;
            end
          end else if (any_next) begin
            if (!hold_empty) begin
              op_valid <= 1'b1;
              op_byte  <= hold;
              hold     <= '0;
            end else begin
              pc  <= pc + 1'b1;
              chk <= next_req;
              st  <= W_EVEN;
            end
          end
        end
        W_EVEN, W_ODD: begin
          st <= IDLE;
          if (take_irq) begin
            irq_stop   <= 1'b1;
            resume_odd <= (st == W_ODD);
            pc         <= pc - 1'b1;
            hold       <= '0;
          end else begin
            op_valid <= 1'b1;
            op_byte  <= (st == W_ODD) ? lo_b : hi_b;
            hold     <= (st == W_ODD) ? '0 : lo_b;
          end
        end
        default: begin
          st        <= IDLE;
          opd_valid <= 1'b1;
          opd_byte  <= hi_b;
          hold      <= lo_b;
        end
      endcase
    end
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({op_valid, opd_valid, irq_stop}));

  // R9
  irq_backup_chk: assert property (@(posedge clk) disable iff (rst)
    irq_stop |-> (pc == $past(pc) - 1'b1) && hold_empty);

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_stop |-> $past(irq_pending) && ($past(wdc) == '0));

  // R12
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> busy && !mem_rd);

  // R3
  hold_no_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !hold_empty && !jump_req && (any_next || opd_req)) |-> !mem_rd);

endmodule

// File: tb/bytecode_fetch_test.sv
module bytecode_fetch_test;
  logic        clk = 0;
  logic        rst;
  logic [15:0] start_pc;
  logic        next_req, next_deaf_req, opd_req, jump_req, jump_odd, jump_deaf;
  logic [15:0] jump_pc;
  logic        irq_pending;
  logic [3:0]  wdc;
  logic        mem_rd;
  logic [15:0] mem_addr;
  logic [15:0] mem_data;
  logic        busy, op_valid, opd_valid, irq_stop, resume_odd;
  logic [7:0]  op_byte, opd_byte;
  logic [15:0] pc;

  int checks = 0;
  int errors = 0;

  logic [15:0] m_pc;
  logic [7:0]  m_hold;
  logic        m_lo_zero;

  always #2.5 clk = ~clk;

  bytecode_fetch uut (
    .clk(clk), .rst(rst), .start_pc(start_pc),
    .next_req(next_req), .next_deaf_req(next_deaf_req), .opd_req(opd_req),
    .jump_req(jump_req), .jump_pc(jump_pc), .jump_odd(jump_odd), .jump_deaf(jump_deaf),
    .irq_pending(irq_pending), .wdc(wdc),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
    .busy(busy), .op_valid(op_valid), .op_byte(op_byte),
    .opd_valid(opd_valid), .opd_byte(opd_byte),
    .irq_stop(irq_stop), .resume_odd(resume_odd), .pc(pc)
  );

  function automatic logic [15:0] word_of(input logic [15:0] a);
    logic [7:0] hi, lo;
    hi = a[7:0] + 8'h11;
    lo = (a[2:0] == 3'd5) ? 8'h00 : (a[7:0] ^ 8'h3C);
    return {hi, lo};
  endfunction

  always @(posedge clk) if (mem_rd) mem_data <= word_of(mem_addr);

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clear_reqs();
    next_req = 0; next_deaf_req = 0; opd_req = 0; jump_req = 0;
    jump_odd = 0; jump_deaf = 0;
  endtask

  // kind: 0 next, 1 next deaf, 2 operand, 3 jump
  task automatic issue(input int kind, input logic [15:0] tgt, input logic odd,
                       input logic jdeaf, input logic poke, input logic both, input string tag);
    int e_kind, e_lat, lat, a_kind;
    logic [7:0] e_byte, a_byte;
    logic e_res;
    logic [15:0] w;
    logic irq_ok;
    irq_ok = irq_pending && (wdc == 0);
    e_res = resume_odd;
    if (kind == 3) begin
      m_pc = tgt; w = word_of(tgt); e_lat = 2;
      if (irq_ok && !jdeaf) begin
        e_kind = 2; e_byte = 0; e_res = odd; m_pc = tgt - 1; m_hold = 0;
      end else if (odd) begin
        e_kind = 0; e_byte = w[7:0]; m_hold = 0;
      end else begin
        e_kind = 0; e_byte = w[15:8]; m_hold = w[7:0];
      end
    end else if (m_hold != 0) begin
      e_kind = (kind == 2) ? 1 : 0; e_byte = m_hold; e_lat = 1; m_hold = 0;
    end else begin
      m_pc = m_pc + 1; w = word_of(m_pc); e_lat = 2;
      if (kind == 0 && irq_ok) begin
        e_kind = 2; e_byte = 0; e_res = 0; m_pc = m_pc - 1; m_hold = 0;
      end else begin
        e_kind = (kind == 2) ? 1 : 0; e_byte = w[15:8]; m_hold = w[7:0];
      end
    end
    @(negedge clk);
    clear_reqs();
    case (kind)
      0: next_req = 1;
      1: next_deaf_req = 1;
      2: opd_req = 1;
      default: begin
        jump_req = 1; jump_pc = tgt; jump_odd = odd; jump_deaf = jdeaf;
        if (both) begin next_req = 1; opd_req = 1; end
      end
    endcase
    @(negedge clk);
    clear_reqs();
    if (poke) opd_req = 1;
    lat = 1;
    while (!(op_valid || opd_valid || irq_stop) && lat < 6) begin
      @(negedge clk);
      clear_reqs();
      lat++;
    end
    a_kind = op_valid ? 0 : opd_valid ? 1 : irq_stop ? 2 : 9;
    a_byte = op_valid ? op_byte : opd_byte;
    check({tag, " kind"}, a_kind == e_kind, a_kind, e_kind);
    check({tag, " latency"}, lat == e_lat, lat, e_lat);
    if (e_kind != 2) check({tag, " byte"}, a_byte == e_byte, a_byte, e_byte);
    else check({tag, " resume"}, resume_odd == e_res, resume_odd, e_res);
    check({tag, " pc"}, pc == m_pc, pc, m_pc);
    m_lo_zero = (e_kind == 0 || e_kind == 1) && e_lat == 2 && m_hold == 0 && !(kind == 3 && odd);
    @(negedge clk);
    check("R12 strobe single cycle", !(op_valid || opd_valid || irq_stop),
          {op_valid, opd_valid, irq_stop}, 0);
  endtask

  function automatic string next_tag();
    if (m_hold != 0) return "R3 buffered";
    if (m_lo_zero) return "R4 zero low byte";
    return "R2 fetch";
  endfunction

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL R12 watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clear_reqs();
    jump_pc = 0; irq_pending = 0; wdc = 0; mem_data = 0;
    start_pc = 16'h00FF; rst = 1;
    m_pc = 16'h00FF; m_hold = 0; m_lo_zero = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R1 reset pc", pc == 16'h00FF, pc, 16'h00FF);
    check("R1 reset strobes", !(op_valid || opd_valid || irq_stop),
          {op_valid, opd_valid, irq_stop}, 0);

    for (int i = 0; i < 48; i++) issue(i % 3 == 2 ? 1 : 0, 0, 0, 0, 0, 0, next_tag());

    for (int i = 0; i < 24; i++) begin
      if (m_hold != 0) issue(2, 0, 0, 0, 0, 0, "R7 operand buffered");
      else issue(2, 0, 0, 0, 0, 0, "R8 operand fetch");
      if (i % 2 == 0) issue(0, 0, 0, 0, 0, 0, next_tag());
    end

    for (int t = 0; t < 16; t++) begin
      logic [15:0] tg;
      tg = 16'h0200 + 16'(t * 7);
      if (t[0]) issue(3, tg, 1, 0, 0, 0, "R6 odd jump");
      else issue(3, tg, 0, 0, 0, t[1], "R5 even jump");
      issue(0, 0, 0, 0, 0, 0, next_tag());
    end

    irq_pending = 1; wdc = 0;
    issue(3, 16'h0300, 1, 1, 0, 0, "R11 deaf odd jump");
    issue(0, 0, 0, 0, 0, 0, "R9 irq even");
    issue(3, 16'h0311, 1, 0, 0, 0, "R9 irq odd jump");
    issue(3, 16'h0322, 0, 0, 0, 0, "R9 irq even jump");
    issue(2, 0, 0, 0, 0, 0, "R8 operand unchecked");
    issue(3, 16'h0330, 1, 1, 0, 0, "R11 deaf odd jump");
    issue(1, 0, 0, 0, 0, 0, "R11 deaf next");
    issue(3, 16'h0342, 0, 1, 0, 0, "R11 deaf even jump");
    issue(1, 0, 0, 0, 0, 0, "R11 deaf next buffered");
    for (int k = 1; k < 16; k += 5) begin
      wdc = 4'(k);
      issue(0, 0, 0, 0, 0, 0, "R10 wdc blocks");
      issue(3, 16'h0350 + 16'(k), 1, 0, 0, 0, "R10 wdc blocks odd");
    end
    irq_pending = 0; wdc = 0;

    issue(3, 16'h0401, 1, 0, 0, 0, "R6 odd jump empties");
    issue(0, 0, 0, 0, 1, 0, "R12 busy poke fetch");
    issue(0, 0, 0, 0, 0, 0, "R12 after poke buffered");
    issue(3, 16'h0410, 0, 0, 0, 1, "R5 jump priority");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule